// File: doc/BRIEF.md
# Cache Push Bus Sequencer

This block takes a dirty cache line that is waiting in a push buffer and writes it back to memory over a synchronous processor bus. A request carries the line address, the four long words of the line, a mask with one bit per dirty long word, and a flag that asks for the bus to stay locked. The sequencer counts the dirty long words. One dirty word goes out as a single long-word write. Two or more go out as a four-beat line burst. A line with nothing dirty finishes at once and never touches the bus.

Each transfer has one address-phase cycle, flagged by `bus_start`, and then a data phase. The data phase lasts until the slave ends it. With acknowledge alone the beat completes. With acknowledge and error together the transfer is retried. With error alone there is a bus error. A slave that cannot burst may raise the burst-inhibit input on the first beat. The sequencer then stops the burst and sends the other three words as separate long-word writes. The requester sees the result as a one-cycle `push_done` or a one-cycle `push_berr`.

Top module: `cache_push_seq`

## Requirements
- R1: A mask with exactly one bit set produces one long-word write: `bus_size` is 2'b00, the address is the line base plus 4·i and the data is `req_line[32i+:32]`, where i is the index of the set bit.
- R2: A mask with two or more bits set produces a line burst. There is a single address phase and `bus_size` is 2'b11. Four beats follow in ascending order, and beat k carries address base+4·k and word k. The address holds steady while a beat waits.
- R3: While the bus is in use, `bus_tm` is 3'b000.
- R4: Acknowledge and error together, on a long-word write or on the first burst beat, cause a new address phase at the same address. This may repeat any number of times.
- R5: Error without acknowledge ends the push. `push_berr` pulses for one cycle on the next cycle and `push_done` stays low.
- R6: Acknowledge and error together on burst beats 1 to 3 count as a bus error, as in R5.
- R7: Burst-inhibit together with acknowledge alone on the first burst beat ends the burst. Words 1, 2 and 3 then go out as separate long-word writes (size 2'b00) at base+4, base+8 and base+12. Burst-inhibit has no effect on any other beat or when it comes with a retry.
- R8: `bus_lock` equals the request's lock flag on every cycle the bus is in use and is low when idle.
- R9: `push_done` is high for exactly one cycle, on the cycle after the final transfer is acknowledged without error.
- R10: Address bits below the line size are ignored. An all-zero mask completes with `push_done` on the cycle after acceptance and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Push request, taken while `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_addr | input | 32 | Line address (low 4 bits ignored) |
| req_line | input | 128 | Line data, word k in bits 32k+31..32k |
| req_dirty | input | 4 | One bit per dirty long word |
| req_lock | input | 1 | Keep the bus locked for the whole push |
| bus_start | output | 1 | Address-phase cycle of a transfer |
| bus_active | output | 1 | Bus in use (address or data phase) |
| bus_addr | output | 32 | Transfer address of the current beat |
| bus_size | output | 2 | 2'b00 long word, 2'b11 line |
| bus_tm | output | 3 | Transfer modifier, 3'b000 for a push |
| bus_wdata | output | 32 | Write data of the current beat |
| bus_lock | output | 1 | Bus lock |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_tea | input | 1 | Transfer error |
| bus_tbi | input | 1 | Burst inhibit |
| push_done | output | 1 | One-cycle pulse: line written |
| push_berr | output | 1 | One-cycle pulse: push ended by bus error |

## Verification
On the first burst beat, burst-inhibit can arrive in the same cycle as a retry response. The bench scripts that cycle and expects the retry to win: the whole line is reissued as a burst, and there are two address phases and four line-size beats. A second case pairs burst-inhibit with a plain acknowledge on a later beat and expects the burst to continue unchanged. The logged writes are compared with an address, size and data list built in the bench from the mask. A full sweep of every dirty mask, with and without the lock flag, supplies the base cases.

// File: rtl/cpush_pkg.sv
package cpush_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_DATA = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        M_SINGLE = 2'd0,
        M_BURST  = 2'd1,
        M_SPLIT  = 2'd2
    } xfer_mode_e;

    typedef enum logic [1:0] {
        RSP_WAIT  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_RETRY = 2'd2,
        RSP_BERR  = 2'd3
    } bus_resp_e;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_LINE = 2'b11;
    localparam logic [2:0] TM_PUSH = 3'b000;

endpackage

// File: rtl/cpush_dirty_scan.sv
module cpush_dirty_scan #(
    parameter int WORDS = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [WORDS-1:0] mask,
    output logic             any_dirty,
    output logic             multi_dirty,
    output logic [IDX_W-1:0] first_idx
);

    logic [WORDS:0]   seen;
    logic [WORDS-1:0] hit;
    logic [WORDS-1:0] dup;

    assign seen[0] = 1'b0;

    // Prefix chain: hit marks the lowest dirty word, dup any word after another one
    for (genvar g = 0; g < WORDS; g++) begin : g_scan
        assign seen[g+1] = seen[g] | mask[g];
        assign hit[g]    = mask[g] & ~seen[g];
        assign dup[g]    = mask[g] & seen[g];
    end

    assign any_dirty   = seen[WORDS];
    assign multi_dirty = |dup;

    always_comb begin
        first_idx = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (hit[i]) first_idx = first_idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/cpush_resp_decode.sv
module cpush_resp_decode
    import cpush_pkg::*;
(
    input  logic      in_data,
    input  logic      late_beat,
    input  logic      first_burst,
    input  logic      ta,
    input  logic      tea,
    input  logic      tbi,
    output bus_resp_e kind,
    output logic      split
);

    always_comb begin
        kind = RSP_WAIT;
        if (in_data) begin
            if (ta && tea)  kind = late_beat ? RSP_BERR : RSP_RETRY;
            else if (tea)   kind = RSP_BERR;
            else if (ta)    kind = RSP_ACK;
        end
    end

    // Burst inhibit matters only on a clean acknowledge of the first burst beat
    assign split = (kind == RSP_ACK) && first_burst && tbi;

endmodule

// File: rtl/cpush_beat_drive.sv
module cpush_beat_drive #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BYTE_SH = $clog2(DATA_W / 8)
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [WORDS*DATA_W-1:0] line,
    input  logic [IDX_W-1:0]        beat,
    output logic [ADDR_W-1:0]       addr,
    output logic [DATA_W-1:0]       wdata
);

    logic [DATA_W-1:0] word [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_unpack
        assign word[g] = line[g*DATA_W +: DATA_W];
    end

    assign addr  = base + (ADDR_W'(beat) << BYTE_SH);
    assign wdata = word[beat];

endmodule

// File: rtl/cache_push_seq.sv
module cache_push_seq
    import cpush_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [WORDS*DATA_W-1:0] req_line,
    input  logic [WORDS-1:0]        req_dirty,
    input  logic                    req_lock,
    output logic                    bus_start,
    output logic                    bus_active,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [1:0]              bus_size,
    output logic [2:0]              bus_tm,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_lock,
    input  logic                    bus_ta,
    input  logic                    bus_tea,
    input  logic                    bus_tbi,
    output logic                    push_done,
    output logic                    push_berr
);

    localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int LINE_W  = WORDS * DATA_W;
    localparam int OFF_W   = $clog2(WORDS * DATA_W / 8);
    localparam int BYTES   = DATA_W / 8;
    localparam logic [IDX_W-1:0]  LAST_BEAT = IDX_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << OFF_W;

    typedef struct packed {
        seq_state_e       st;
        xfer_mode_e       mode;
        logic [IDX_W-1:0] beat;
        logic [ADDR_W-1:0] base;
        logic [LINE_W-1:0] line;
        logic             lock;
        logic             done;
        logic             berr;
    } seq_t;

    seq_t q, d;

    logic             any_dirty, multi_dirty;
    logic [IDX_W-1:0] first_idx;
    bus_resp_e        kind;
    logic             split;
    logic             in_data, late_beat, first_burst, last_xfer;

    cpush_dirty_scan #(.WORDS(WORDS)) u_scan (
        .mask        (req_dirty),
        .any_dirty   (any_dirty),
        .multi_dirty (multi_dirty),
        .first_idx   (first_idx)
    );

    assign in_data     = (q.st == S_DATA);
    assign late_beat   = (q.mode == M_BURST) && (q.beat != '0);
    assign first_burst = (q.mode == M_BURST) && (q.beat == '0);
    assign last_xfer   = (q.mode == M_SINGLE) || (q.beat == LAST_BEAT);

    cpush_resp_decode u_resp (
        .in_data     (in_data),
        .late_beat   (late_beat),
        .first_burst (first_burst),
        .ta          (bus_ta),
        .tea         (bus_tea),
        .tbi         (bus_tbi),
        .kind        (kind),
        .split       (split)
    );

    cpush_beat_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_beat (
        .base  (q.base),
        .line  (q.line),
        .beat  (q.beat),
        .addr  (bus_addr),
        .wdata (bus_wdata)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.berr = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.base = req_addr & BASE_MASK;
                    d.line = req_line;
                    d.lock = req_lock;
                    if (!any_dirty) begin
                        d.done = 1'b1;
                    end else if (multi_dirty) begin
                        d.st   = S_ADDR;
                        d.mode = M_BURST;
                        d.beat = '0;
                    end else begin
                        d.st   = S_ADDR;
                        d.mode = M_SINGLE;
                        d.beat = first_idx;
                    end
                end
            end
            S_ADDR: d.st = S_DATA;
            S_DATA: begin
                case (kind)
                    RSP_RETRY: d.st = S_ADDR;
                    RSP_BERR: begin
                        d.st   = S_IDLE;
                        d.berr = 1'b1;
                    end
                    RSP_ACK: begin
                        if (last_xfer) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else if (split) begin
                            d.mode = M_SPLIT;
                            d.beat = q.beat + 1'b1;
                            d.st   = S_ADDR;
                        end else if (q.mode == M_BURST) begin
                            d.beat = q.beat + 1'b1;
                        end else begin
                            d.beat = q.beat + 1'b1;
                            d.st   = S_ADDR;
                        end
                    end
                    default: ;
                endcase
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == S_IDLE);
    assign bus_active = (q.st != S_IDLE);
    assign bus_start  = (q.st == S_ADDR);
    assign bus_size   = (q.mode == M_BURST) ? SZ_LINE : SZ_LONG;
    assign bus_tm     = TM_PUSH;
    assign bus_lock   = q.lock && bus_active;
    assign push_done  = q.done;
    assign push_berr  = q.berr;

    // R2: a waiting beat keeps its address
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !bus_start && !bus_ta && !bus_tea) |=> $stable(bus_addr));

    // R4: retry on a retryable transfer reissues the address phase at the same address
    p_retry_reissue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && bus_ta && bus_tea && !late_beat) |=> (bus_start && $stable(bus_addr)));

    // R5: error alone ends the push with a bus-error pulse
    p_berr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && bus_tea && !bus_ta) |=> (push_berr && !push_done && req_ready));

    // R6: retry on a later burst beat is a bus error
    p_late_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && late_beat && bus_ta && bus_tea) |=> push_berr);

    // R7: burst inhibit on the first beat turns the rest into long-word writes
    p_fallback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && first_burst && bus_ta && !bus_tea && bus_tbi) |=>
        (bus_start && bus_size == SZ_LONG && bus_addr == $past(bus_addr) + ADDR_W'(BYTES)));

    // R9: clean acknowledge of the final transfer gives done next cycle
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && last_xfer && bus_ta && !bus_tea) |=> (push_done && !push_berr));

    // R8: lock is never driven while idle
    p_lock_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> !bus_lock);

endmodule

// File: tb/cache_push_seq_tb.sv
module cache_push_seq_tb;

    localparam int C_WAIT = 0, C_ACK = 1, C_RETRY = 2, C_ERR = 3, C_ACK_TBI = 4, C_RETRY_TBI = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [127:0] req_line = '0;
    logic [3:0]   req_dirty = '0;
    logic         req_lock = 1'b0;
    logic         bus_start, bus_active, bus_lock, push_done, push_berr;
    logic [31:0]  bus_addr, bus_wdata;
    logic [1:0]   bus_size;
    logic [2:0]   bus_tm;
    logic         bus_ta = 1'b0, bus_tea = 1'b0, bus_tbi = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0;
    int script [32];
    int ptr, starts, n_log, tm_bad, lock_bad, done_cnt, berr_cnt, done_cyc, last_ack_cyc;
    logic        cur_lock;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [1:0]  log_size [16];
    logic [31:0] e_addr [4];
    logic [31:0] e_data [4];
    logic [1:0]  e_size [4];
    bit          finished = 0;

    cache_push_seq u_dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_line, .req_dirty, .req_lock,
        .bus_start, .bus_active, .bus_addr, .bus_size, .bus_tm, .bus_wdata, .bus_lock,
        .bus_ta, .bus_tea, .bus_tbi, .push_done, .push_berr
    );

    always #4 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Bus slave and monitor
    initial begin
        forever begin
            @(negedge clk);
            bus_ta = 1'b0; bus_tea = 1'b0; bus_tbi = 1'b0;
            if (bus_active) begin
                if (bus_tm != 3'b000) tm_bad++;
                if (bus_lock != cur_lock) lock_bad++;
            end
            if (bus_start) starts++;
            if (bus_active && !bus_start) begin
                int code;
                code = (ptr < 32) ? script[ptr] : C_ACK;
                ptr++;
                bus_ta  = (code == C_ACK) || (code == C_ACK_TBI) || (code == C_RETRY) || (code == C_RETRY_TBI);
                bus_tea = (code == C_RETRY) || (code == C_RETRY_TBI) || (code == C_ERR);
                bus_tbi = (code == C_ACK_TBI) || (code == C_RETRY_TBI);
                if ((code == C_ACK || code == C_ACK_TBI) && n_log < 16) begin
                    log_addr[n_log] = bus_addr;
                    log_data[n_log] = bus_wdata;
                    log_size[n_log] = bus_size;
                    n_log++;
                    last_ack_cyc = cyc;
                end
            end
            if (push_done) begin done_cnt++; done_cyc = cyc; end
            if (push_berr) berr_cnt++;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [3:0] m, input logic lk, input int i);
        return 32'hC0DE_0000 ^ (32'(m) << 8) ^ (32'(lk) << 16) ^ 32'(i) ^ (32'(i) << 24);
    endfunction

    task automatic prep();
        @(negedge clk); #1;
        for (int i = 0; i < 32; i++) script[i] = C_ACK;
        ptr = 0; starts = 0; n_log = 0; tm_bad = 0; lock_bad = 0;
        done_cnt = 0; berr_cnt = 0; done_cyc = -100; last_ack_cyc = -100;
    endtask

    // kind: 1 single word idx, 2 burst, 3 burst split after beat 0
    task automatic build_exp(input logic [31:0] base, input logic [3:0] m, input logic lk,
                             input int kind, input int idx);
        for (int i = 0; i < 4; i++) begin
            e_addr[i] = base + 32'(4 * i);
            e_data[i] = word_of(m, lk, i);
            e_size[i] = (kind == 2 || (kind == 3 && i == 0)) ? 2'b11 : 2'b00;
        end
        if (kind == 1) begin
            e_addr[0] = base + 32'(4 * idx);
            e_data[0] = word_of(m, lk, idx);
            e_size[0] = 2'b00;
        end
    endtask

    task automatic run(input string tag, input logic [31:0] addr, input logic [3:0] m,
                       input logic lk, input int exp_n, input int exp_starts, input bit exp_done);
        cur_lock = lk;
        @(negedge clk); #1;
        req_addr = addr; req_dirty = m; req_lock = lk;
        for (int i = 0; i < 4; i++) req_line[32*i +: 32] = word_of(m, lk, i);
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (done_cnt != 0 || berr_cnt != 0) break;
            @(negedge clk); #1;
        end
        repeat (3) begin @(negedge clk); #1; end
        check(tag, "address phases", starts, exp_starts);
        check(tag, "acked writes", n_log, exp_n);
        for (int i = 0; i < exp_n && i < n_log; i++) begin
            check(tag, "beat address", log_addr[i], e_addr[i]);
            check(tag, "beat data", log_data[i], e_data[i]);
            check(tag, "beat size", log_size[i], e_size[i]);
        end
        check("R3", "transfer modifier", tm_bad, 0);
        check("R8", "lock while busy", lock_bad, 0);
        check("R8", "lock when idle", bus_lock, 0);
        check(exp_done ? "R9" : "R5", "done pulses", done_cnt, exp_done ? 1 : 0);
        check(exp_done ? "R9" : "R5", "berr pulses", berr_cnt, exp_done ? 0 : 1);
        if (exp_done && exp_n > 0) check("R9", "done timing", done_cyc, last_ack_cyc + 1);
        check(tag, "ready after push", req_ready, 1);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R9", "reset done", push_done, 0);
        check("R5", "reset berr", push_berr, 0);
        check("R8", "reset active", bus_active, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R10", "reset ready", req_ready, 1);

        // Sweep every mask with and without lock; low address bits set to be ignored (R10)
        for (int mi = 0; mi < 16; mi++) begin
            for (int li = 0; li < 2; li++) begin
                logic [3:0]  m;
                logic        lk;
                logic [31:0] base;
                int cnt, idx;
                m = 4'(mi); lk = li[0];
                base = 32'h0000_4000 + 32'(mi * 256);
                cnt = $countones(m);
                idx = 0;
                for (int b = 3; b >= 0; b--) if (m[b]) idx = b;
                prep();
                if (lk) script[0] = C_WAIT;
                if (cnt == 0) begin
                    build_exp(base, m, lk, 2, 0);
                    run("R10", base | (lk ? 32'h9 : 32'h0), m, lk, 0, 0, 1);
                end else if (cnt == 1) begin
                    build_exp(base, m, lk, 1, idx);
                    run("R1", base | (lk ? 32'h9 : 32'h0), m, lk, 1, 1, 1);
                end else begin
                    build_exp(base, m, lk, 2, 0);
                    run("R2", base | (lk ? 32'h9 : 32'h0), m, lk, 4, 1, 1);
                end
            end
        end

        // R4: long-word write retried three times
        prep();
        script[0] = C_RETRY; script[1] = C_RETRY; script[2] = C_WAIT; script[3] = C_RETRY;
        build_exp(32'h0000_8000, 4'b0100, 1'b1, 1, 2);
        run("R4", 32'h0000_8000, 4'b0100, 1'b1, 1, 4, 1);

        // R4: first burst beat retried twice
        prep();
        script[0] = C_RETRY; script[1] = C_RETRY;
        build_exp(32'h0000_8100, 4'b1010, 1'b0, 2, 0);
        run("R4", 32'h0000_8100, 4'b1010, 1'b0, 4, 3, 1);

        // R6: retry on beat 2 of a burst is a bus error
        prep();
        script[2] = C_RETRY;
        build_exp(32'h0000_8200, 4'b1111, 1'b1, 2, 0);
        run("R6", 32'h0000_8200, 4'b1111, 1'b1, 2, 1, 0);

        // R6: retry on the last beat
        prep();
        script[3] = C_RETRY;
        build_exp(32'h0000_8300, 4'b0011, 1'b0, 2, 0);
        run("R6", 32'h0000_8300, 4'b0011, 1'b0, 3, 1, 0);

        // R5: error alone on the first burst beat
        prep();
        script[0] = C_ERR;
        build_exp(32'h0000_8400, 4'b0111, 1'b0, 2, 0);
        run("R5", 32'h0000_8400, 4'b0111, 1'b0, 0, 1, 0);

        // R5: error alone on a long-word write after a retry
        prep();
        script[0] = C_RETRY; script[1] = C_ERR;
        build_exp(32'h0000_8500, 4'b1000, 1'b1, 1, 3);
        run("R5", 32'h0000_8500, 4'b1000, 1'b1, 0, 2, 0);

        // R7: burst inhibit on the first beat splits the rest into long words
        prep();
        script[0] = C_WAIT; script[1] = C_ACK_TBI;
        build_exp(32'h0000_8600, 4'b1001, 1'b1, 3, 0);
        run("R7", 32'h0000_8600, 4'b1001, 1'b1, 4, 4, 1);

        // R7 with R4: burst inhibit together with retry on the first beat -> retry wins
        prep();
        script[0] = C_RETRY_TBI;
        build_exp(32'h0000_8700, 4'b0110, 1'b0, 2, 0);
        run("R7", 32'h0000_8700, 4'b0110, 1'b0, 4, 2, 1);

        // R7: burst inhibit on beat 2 has no effect
        prep();
        script[2] = C_ACK_TBI;
        build_exp(32'h0000_8800, 4'b1100, 1'b0, 2, 0);
        run("R7", 32'h0000_8800, 4'b1100, 1'b0, 4, 1, 1);

        // R4 in split mode: a fallback long-word write may be retried
        prep();
        script[0] = C_ACK_TBI; script[1] = C_RETRY; script[2] = C_RETRY;
        build_exp(32'h0000_8900, 4'b1110, 1'b1, 3, 0);
        run("R4", 32'h0000_8900, 4'b1110, 1'b1, 4, 6, 1);

        // R5 in split mode: error on the second fallback write
        prep();
        script[0] = C_ACK_TBI; script[2] = C_ERR;
        build_exp(32'h0000_8A00, 4'b0101, 1'b0, 3, 0);
        run("R5", 32'h0000_8A00, 4'b0101, 1'b0, 2, 3, 0);

        finish_up();
    end

endmodule